// File: doc/BRIEF.md
# Single-Wire Bus Registration-Code Slave (ROM Command Layer)

This block is the command layer of a single-wire bus slave that carries a fixed 64-bit registration code. It sits above a signalling layer that measures pulse widths on the shared line. That layer reports three things: a detected bus reset, the start of each time slot, and the line level sampled in that slot. In return it takes one bit, `pull_o`, and pulls the line low for the current slot whenever that bit is high. The slave can only pull low or let go. It never drives high, so several slaves on one line combine as a wired-AND.

After a bus reset the slave asks for a presence pulse. It then collects an 8-bit command. Read Code sends out the whole 64-bit code. Search Code takes part in the master's bit-by-bit search, in which every bit of the code costs three slots. In the first slot the slave sends its bit, in the second it sends the complement, and in the third it compares its bit with the bit the master wrote. The code is built from two parameters, an 8-bit family byte and a 48-bit serial number, and an 8-bit check byte computed at elaboration time is added to them.

Top module: `owire_rom_slave`

## Requirements
- R1: One clock after `bus_rst_i` is sampled high, `presence_o` is high for exactly one clock. `presence_o` is never high at any other time, and it is low after `rst_n`.
- R2: Before the first bus reset after `rst_n`, slots have no effect: `pull_o` stays 0 and no command is taken in.
- R3: A command is 8 bits taken from 8 consecutive slots, first bit = least significant. Code 0x33 selects Read Code and 0xF0 selects Search Code.
- R4: Read Code sends code bit i in the i-th slot after the command, i = 0..63. `pull_o` = 1 in that slot means the bit is 0. Bits 0..7 hold the family byte, bits 8..55 hold the serial number (least significant bit first) and bits 56..63 hold the check byte.
- R5: The check byte is the CRC with polynomial x^8+x^5+x^4+1 (reflected form 0x8C, initial value 0), fed bits 0..55 of the code in order.
- R6: Search Code walks the code from bit 0 upward. For each bit, in the first slot the slave sends its bit value, and in the second slot it sends the complement of that bit.
- R7: In the third slot of a search bit, the slave samples the line. If the sampled value differs from its own bit, the slave releases the line (`pull_o` = 0) for every remaining slot until the next bus reset.
- R8: A command other than 0x33 or 0xF0 makes the slave ignore all slots until the next bus reset, with `pull_o` = 0.
- R9: A bus reset at any point, including the middle of a command, a read or a search, aborts the current work. `pull_o` is 0 on the next clock, and a new command can follow.
- R10: The slave pulls the line only in slots where it sends data. During command slots and during the third slot of a search bit, `pull_o` is 0.
- R11: After the 64th Read Code bit, or after the 64th search bit, the slave releases the line until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rst_i | input | 1 | One-clock pulse: the signalling layer detected a bus reset |
| slot_i | input | 1 | One-clock pulse: a time slot has been completed |
| slot_bit_i | input | 1 | Line level sampled in the slot marked by `slot_i` |
| presence_o | output | 1 | One-clock request to send a presence pulse |
| pull_o | output | 1 | Pull the line low during the current slot (open-drain enable) |

## Verification
Some rules are checked by assertions on every clock: presence following a reset, release after a reset, the true-then-complement pair in each search bit, drop-out on a mismatched third slot, staying idle once idle, and the step-by-one walk through the code during Read Code. Other behaviours need whole transactions and are shown only by the bench scenarios. These are the exact 64-bit value returned and its check byte, the code recovered by a search that follows the slave, a search broken off at a random bit, random unknown commands, and resets placed at random points in a read.

// File: rtl/owire_rom_pkg.sv
package owire_rom_pkg;

    localparam int CODE_BITS = 64;
    localparam int IDX_W     = $clog2(CODE_BITS);
    localparam int BODY_BITS = CODE_BITS - 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CMD    = 3'd1,
        ST_READ   = 3'd2,
        ST_SEARCH = 3'd3,
        ST_DONE   = 3'd4
    } ow_state_e;

    typedef enum logic [1:0] {
        CK_NONE   = 2'd0,
        CK_READ   = 2'd1,
        CK_SEARCH = 2'd2
    } ow_cmd_e;

    typedef struct packed {
        ow_state_e        st;
        logic [IDX_W-1:0] idx;
        logic [1:0]       phase;
        logic [7:0]       cmd;
        logic [2:0]       cnt;
        logic             pres;
    } ow_regs_t;

    // Reflected CRC-8, polynomial x^8+x^5+x^4+1, bit 0 first.
    function automatic logic [7:0] ow_crc8(input logic [BODY_BITS-1:0] body);
        logic [7:0] acc;
        logic       fb;
        acc = 8'h00;
        for (int i = 0; i < BODY_BITS; i++) begin
            fb  = acc[0] ^ body[i];
            acc = acc >> 1;
            if (fb) acc = acc ^ 8'h8C;
        end
        return acc;
    endfunction

endpackage

// File: rtl/owire_cmd_decode.sv
module owire_cmd_decode
    import owire_rom_pkg::*;
#(
    parameter logic [7:0] READ_CODE   = 8'h33,
    parameter logic [7:0] SEARCH_CODE = 8'hF0
) (
    input  logic [7:0] code_i,
    output ow_cmd_e    kind_o
);
    always_comb begin
        if (code_i == READ_CODE)        kind_o = CK_READ;
        else if (code_i == SEARCH_CODE) kind_o = CK_SEARCH;
        else                            kind_o = CK_NONE;
    end
endmodule

// File: rtl/owire_code_store.sv
module owire_code_store
    import owire_rom_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h01,
    parameter logic [47:0] SERIAL = 48'h0000_0000_0001
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);
    localparam logic [BODY_BITS-1:0] BODY = {SERIAL, FAMILY};
    localparam logic [7:0]           CHK  = ow_crc8(BODY);
    localparam logic [CODE_BITS-1:0] CODE = {CHK, BODY};

    assign bit_o = CODE[idx_i];
endmodule

// File: rtl/owire_rom_slave.sv
module owire_rom_slave
    import owire_rom_pkg::*;
#(
    parameter logic [7:0]  FAMILY      = 8'h01,
    parameter logic [47:0] SERIAL      = 48'h0000_0000_0001,
    parameter logic [7:0]  READ_CODE   = 8'h33,
    parameter logic [7:0]  SEARCH_CODE = 8'hF0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst_i,
    input  logic slot_i,
    input  logic slot_bit_i,
    output logic presence_o,
    output logic pull_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_BITS - 1);

    ow_regs_t r_d, r_q;

    logic             rom_bit;
    logic [7:0]       cmd_next;
    ow_cmd_e          kind;
    ow_state_e        st_q;
    logic [1:0]       phase_q;
    logic [IDX_W-1:0] idx_q;

    assign st_q    = r_q.st;
    assign phase_q = r_q.phase;
    assign idx_q   = r_q.idx;

    // Bits arrive least significant first: shift in at the top.
    assign cmd_next = {slot_bit_i, r_q.cmd[7:1]};

    owire_code_store #(
        .FAMILY (FAMILY),
        .SERIAL (SERIAL)
    ) u_store (
        .idx_i (r_q.idx),
        .bit_o (rom_bit)
    );

    owire_cmd_decode #(
        .READ_CODE   (READ_CODE),
        .SEARCH_CODE (SEARCH_CODE)
    ) u_decode (
        .code_i (cmd_next),
        .kind_o (kind)
    );

    always_comb begin
        r_d      = r_q;
        r_d.pres = 1'b0;
        if (bus_rst_i) begin
            r_d.st    = ST_CMD;
            r_d.idx   = '0;
            r_d.phase = 2'd0;
            r_d.cmd   = 8'h00;
            r_d.cnt   = 3'd0;
            r_d.pres  = 1'b1;
        end else if (slot_i) begin
            unique case (r_q.st)
                ST_CMD: begin
                    r_d.cmd = cmd_next;
                    r_d.cnt = r_q.cnt + 3'd1;
                    if (r_q.cnt == 3'd7) begin
                        r_d.idx   = '0;
                        r_d.phase = 2'd0;
                        unique case (kind)
                            CK_READ:   r_d.st = ST_READ;
                            CK_SEARCH: r_d.st = ST_SEARCH;
                            default:   r_d.st = ST_DONE;
                        endcase
                    end
                end
                ST_READ: begin
                    if (r_q.idx == LAST_IDX) r_d.st  = ST_DONE;
                    else                     r_d.idx = r_q.idx + 1'b1;
                end
                ST_SEARCH: begin
                    unique case (r_q.phase)
                        2'd0:    r_d.phase = 2'd1;
                        2'd1:    r_d.phase = 2'd2;
                        default: begin
                            r_d.phase = 2'd0;
                            if (slot_bit_i != rom_bit)    r_d.st  = ST_DONE;
                            else if (r_q.idx == LAST_IDX) r_d.st  = ST_DONE;
                            else                          r_d.idx = r_q.idx + 1'b1;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Drive-low enable: a '0' data bit is sent by pulling the line.
    always_comb begin
        unique case (r_q.st)
            ST_READ:   pull_o = ~rom_bit;
            ST_SEARCH: begin
                unique case (r_q.phase)
                    2'd0:    pull_o = ~rom_bit;
                    2'd1:    pull_o = rom_bit;
                    default: pull_o = 1'b0;
                endcase
            end
            default:   pull_o = 1'b0;
        endcase
    end

    assign presence_o = r_q.pres;

endmodule

// File: rtl/owire_rom_slave_chk.sv
module owire_rom_slave_chk
    import owire_rom_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rst_i,
    input logic             slot_i,
    input logic             slot_bit_i,
    input logic             presence_o,
    input logic             pull_o,
    input ow_state_e        st,
    input logic [1:0]       phase,
    input logic [IDX_W-1:0] idx,
    input logic             rom_bit
);
    p_presence_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_i |=> presence_o);

    p_presence_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        presence_o |-> $past(bus_rst_i));

    p_idle_before_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !bus_rst_i) |=> (st == ST_IDLE && !pull_o));

    p_read_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && slot_i && !bus_rst_i && idx != IDX_W'(CODE_BITS - 1))
        |=> (st == ST_READ && idx == IDX_W'($past(idx) + 1'b1)));

    p_search_complement_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEARCH && phase == 2'd0 && slot_i && !bus_rst_i)
        |=> (pull_o != $past(pull_o)));

    p_search_dropout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEARCH && phase == 2'd2 && slot_i && !bus_rst_i && slot_bit_i != rom_bit)
        |=> (st == ST_DONE && !pull_o));

    p_stay_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && !bus_rst_i) |=> (st == ST_DONE && !pull_o));

    p_release_on_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_i |=> (!pull_o && st == ST_CMD));
endmodule

bind owire_rom_slave owire_rom_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst_i  (bus_rst_i),
    .slot_i     (slot_i),
    .slot_bit_i (slot_bit_i),
    .presence_o (presence_o),
    .pull_o     (pull_o),
    .st         (st_q),
    .phase      (phase_q),
    .idx        (idx_q),
    .rom_bit    (rom_bit)
);

// File: tb/owire_rom_slave_bench.sv
`timescale 1ns/1ps
module owire_rom_slave_bench;

    localparam logic [7:0]  FAM = 8'h01;
    localparam logic [47:0] SER = 48'hA1B2_C3D4_E5F6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst_i = 1'b0;
    logic slot_i = 1'b0;
    logic slot_bit_i = 1'b0;
    logic presence_o;
    logic pull_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    owire_rom_slave #(
        .FAMILY (FAM),
        .SERIAL (SER)
    ) u_owire_rom_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst_i  (bus_rst_i),
        .slot_i     (slot_i),
        .slot_bit_i (slot_bit_i),
        .presence_o (presence_o),
        .pull_o     (pull_o)
    );

    // Bench model of the check byte: shift-register form, feedback into bits 7,3,2.
    function automatic logic [7:0] ref_crc(input logic [55:0] body);
        logic [7:0] s;
        logic       x;
        s = 8'h00;
        for (int k = 0; k < 56; k++) begin
            x = body[k] ^ s[0];
            s = {x, s[7:1]};
            s[3] = s[3] ^ x;
            s[2] = s[2] ^ x;
        end
        return s;
    endfunction

    function automatic logic [63:0] ref_code();
        return {ref_crc({SER, FAM}), SER, FAM};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic slot(input logic b);
        slot_i = 1'b1;
        slot_bit_i = b;
        @(negedge clk);
        slot_i = 1'b0;
        slot_bit_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_reset();
        bus_rst_i = 1'b1;
        @(negedge clk);
        bus_rst_i = 1'b0;
        check("R1 presence", 64'(presence_o), 64'd1);
        check("R9 released", 64'(pull_o), 64'd0);
        @(negedge clk);
        check("R1 single pulse", 64'(presence_o), 64'd0);
    endtask

    task automatic send_cmd(input logic [7:0] c);
        logic any;
        any = 1'b0;
        for (int i = 0; i < 8; i++) begin
            any = any | pull_o;
            slot(c[i]);
        end
        check("R10 no pull in command", 64'(any), 64'd0);
    endtask

    task automatic read_bits(input int n, output logic [63:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            got[i] = ~pull_o;
            slot(~pull_o);
        end
    endtask

    task automatic count_pulls(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (pull_o) cnt++;
            slot($urandom_range(1, 0) == 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] exp_code;
        logic [63:0] got;
        int pulls;
        void'($urandom(32'h5EED_1234));
        exp_code = ref_code();

        repeat (3) @(negedge clk);
        check("R1 reset state presence", 64'(presence_o), 64'd0);
        check("R2 reset state pull", 64'(pull_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: slots before any bus reset are ignored.
        for (int i = 0; i < 8; i++) slot(READ_BIT(i));
        count_pulls(16, pulls);
        check("R2 ignored before reset", 64'(pulls), 64'd0);

        // R3/R4/R5: Read Code.
        bus_reset();
        send_cmd(8'h33);
        read_bits(64, got);
        check("R4 read code", got, exp_code);
        check("R4 family field", 64'(got[7:0]), 64'(FAM));
        check("R5 check byte", 64'(got[63:56]), 64'(ref_crc(got[55:0])));
        count_pulls(10, pulls);
        check("R11 release after read", 64'(pulls), 64'd0);

        // R6: search following the slave's own bits.
        bus_reset();
        send_cmd(8'hF0);
        got = '0;
        for (int i = 0; i < 64; i++) begin
            logic t, c;
            t = ~pull_o;
            slot(t);
            c = ~pull_o;
            slot(c);
            check("R6 complement pair", 64'({t, c}), 64'({exp_code[i], ~exp_code[i]}));
            check("R10 no pull in third slot", 64'(pull_o), 64'd0);
            got[i] = t;
            slot(t);
        end
        check("R6 search result", got, exp_code);
        count_pulls(6, pulls);
        check("R11 release after search", 64'(pulls), 64'd0);

        // Random scenarios.
        for (int it = 0; it < 24; it++) begin
            int mode;
            mode = $urandom_range(2, 0);
            if (mode == 0) begin
                int k;
                k = $urandom_range(63, 0);
                bus_reset();
                send_cmd(8'hF0);
                for (int i = 0; i < k; i++) begin
                    slot(~pull_o);
                    slot(~pull_o);
                    slot(exp_code[i]);
                end
                slot(~pull_o);
                slot(~pull_o);
                slot(~exp_code[k]);
                count_pulls(3 * (63 - k) + 3, pulls);
                check("R7 dropout after mismatch", 64'(pulls), 64'd0);
            end else if (mode == 1) begin
                logic [7:0] c;
                c = 8'($urandom());
                if (c == 8'h33 || c == 8'hF0) c = 8'h55;
                bus_reset();
                send_cmd(c);
                count_pulls(64, pulls);
                check("R8 unknown command idle", 64'(pulls), 64'd0);
            end else begin
                int k;
                k = $urandom_range(62, 1);
                bus_reset();
                send_cmd(8'h33);
                read_bits(k, got);
                bus_reset();
                send_cmd(8'h33);
                read_bits(64, got);
                check("R9 read after abort", got, exp_code);
            end
        end

        // R9: reset in the middle of a command byte.
        bus_reset();
        for (int i = 0; i < 4; i++) slot(1'b1);
        bus_reset();
        send_cmd(8'h33);
        read_bits(64, got);
        check("R9 abort inside command", got, exp_code);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    function automatic logic READ_BIT(input int i);
        logic [7:0] c;
        c = 8'h33;
        return c[i];
    endfunction

endmodule